// File: doc/BRIEF.md
# Media Exception Status Tracker

This block holds the exception state of the media (SIMD) units in a two-slot VLIW core. It keeps two status registers. The primary register has a trap-cause field, a sticky accumulated-overflow flag, an overflow flag, a saturation-indicator field and an enable bit for immediate overflow interrupts. The secondary register has only an overflow flag and a saturation field, and it serves the second media slot.

Each cycle the pipeline can report one media exception. A report carries a cause code, saturation flags and the slot that issued it. A core-variant select picks between two policies. In the default policy, overflows are sorted by slot and later collected by a media-trap instruction. In the alternate policy, every overflow goes to the primary register, and an overflow can raise an interrupt at once when the enable bit is set. Software reads and writes both registers through a simple register port.

Reports, trap strobes and register writes are plain per-cycle strobes. The block accepts one of each in every cycle, so it never applies back-pressure and has no ready signal. The only output is a one-cycle program-interrupt request.

Top module: `media_exc_tracker`

## Requirements
- R1: After reset both registers read as zero and `irq_pulse` is low.
- R2: The cause field (primary word bits [2:0]; 0 = none, 1 = overflow, 2..7 = other causes) is loaded from a valid report only while it holds 0. A nonzero cause therefore stays in place until software writes the field.
- R3: An overflow report (cause 1) sets the overflow flag (bit 4) in the selected register and ORs `rpt_sat` into that register's saturation field (bits [11:8]).
- R4: With `alt_variant` = 0, an overflow from slot 1 (`rpt_slot` = 1) goes to the secondary register. An overflow from slot 0 goes to the primary register.
- R5: With `alt_variant` = 1, every overflow goes to the primary register, whichever slot issued it.
- R6: With `alt_variant` = 1 and the enable bit (primary bit 5) set, an overflow raises `irq_pulse` in the next cycle and leaves the accumulated-overflow flag (primary bit 3) unchanged.
- R7: Every other overflow sets the accumulated-overflow flag, whichever slot issued it. The flag stays set until software writes it.
- R8: A `trap_strobe` raises `irq_pulse` in the next cycle if the accumulated-overflow flag is set. With `alt_variant` = 0 it also does so if the cause field is nonzero.
- R9: A report whose cause is not 1 changes only the cause field.
- R10: `sw_sel` = 0 selects the primary register and 1 selects the secondary. Writes load the fields at the bit positions given above, and all other bits read as 0. The secondary register keeps only bits 4 and [11:8]. When a write and an exception update reach the same register in one cycle, the exception update wins for the bits it touches.
- R11: `irq_pulse` is registered. It is high only in the cycle right after a triggering overflow or trap strobe.
- R12: The trap check and the enable-bit check use the register contents from before the same cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_variant | input | 1 | 0 = default policy, 1 = alternate policy |
| rpt_valid | input | 1 | An exception report is present this cycle |
| rpt_type | input | 3 | Reported cause code |
| rpt_sat | input | 4 | Saturation flags of the report |
| rpt_slot | input | 1 | Issuing media slot (0 or 1) |
| trap_strobe | input | 1 | Media-trap instruction executes this cycle |
| sw_wr_en | input | 1 | Register write strobe |
| sw_sel | input | 1 | Register select for read and write |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data of the selected register |
| irq_pulse | output | 1 | One-cycle program-interrupt request |

## Verification
The assertions assume that reports, trap strobes and writes are idle while reset is held. They also assume that `alt_variant` is stable enough for a trigger and its interrupt cycle to share one policy, and they check only the cycle after each trigger. The bench drives every input at a fixed offset after the falling edge and keeps all strobes low during reset. It changes the policy only between directed phases, or at random between whole cycles, so each trigger is judged against the policy that was present at its clock edge.

// File: rtl/mx_pkg.sv
package mx_pkg;
  localparam int SAT_W = 4;
  localparam int TT_W  = 3;

  typedef logic [TT_W-1:0] ttype_t;

  localparam ttype_t TT_NONE = 3'd0;
  localparam ttype_t TT_OVF  = 3'd1;

  // bit positions inside the software-visible word
  localparam int F_TYPE = 0;
  localparam int F_AOVF = 3;
  localparam int F_OVF  = 4;
  localparam int F_MODE = 5;
  localparam int F_SAT  = 8;
  localparam int WORD_MIN = F_SAT + SAT_W;

  typedef struct packed {
    ttype_t           ttype;
    logic             aovf;
    logic             ovf;
    logic             mode;
    logic [SAT_W-1:0] sat;
  } mx_stat_t;
endpackage

// File: rtl/mx_exc_decode.sv
module mx_exc_decode
  import mx_pkg::*;
(
  input  logic     alt_variant,
  input  logic     rpt_valid,
  input  ttype_t   rpt_type,
  input  logic     rpt_slot,
  input  logic     trap_strobe,
  input  mx_stat_t cur_a,
  output logic     type_load,
  output logic     ovf_to_a,
  output logic     ovf_to_b,
  output logic     aovf_set,
  output logic     irq_now
);
  logic is_ovf;
  logic imm_irq;
  logic trap_hit;

  always_comb begin
    is_ovf    = rpt_valid && (rpt_type == TT_OVF);
    ovf_to_b  = is_ovf && !alt_variant && rpt_slot;
    ovf_to_a  = is_ovf && !ovf_to_b;
    imm_irq   = is_ovf && alt_variant && cur_a.mode;
    aovf_set  = is_ovf && !imm_irq;
    type_load = rpt_valid && (cur_a.ttype == TT_NONE) && (rpt_type != TT_NONE);
    trap_hit  = trap_strobe &&
                (cur_a.aovf || (!alt_variant && (cur_a.ttype != TT_NONE)));
    irq_now   = imm_irq || trap_hit;
  end
endmodule

// File: rtl/mx_status_reg.sv
module mx_status_reg
  import mx_pkg::*;
#(
  parameter bit HAS_CTRL = 1'b1,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf_set,
  input  logic [SAT_W-1:0]  sat_or,
  input  logic              type_load,
  input  ttype_t            type_val,
  input  logic              aovf_set,
  output mx_stat_t          stat,
  output logic [DATA_W-1:0] rword
);
  mx_stat_t nxt;
  mx_stat_t base;

  // software write first, exception update layered on top
  always_comb begin
    base = stat;
    if (wr_en) begin
      base.ovf   = wdata[F_OVF];
      base.sat   = wdata[F_SAT +: SAT_W];
      base.ttype = wdata[F_TYPE +: TT_W];
      base.aovf  = wdata[F_AOVF];
      base.mode  = wdata[F_MODE];
    end
    nxt = base;
    if (ovf_set) begin
      nxt.ovf = 1'b1;
      nxt.sat = base.sat | sat_or;
    end
  end

  generate
    if (HAS_CTRL) begin : g_ctrl
      mx_stat_t full;
      always_comb begin
        full = nxt;
        if (type_load) full.ttype = type_val;
        if (aovf_set)  full.aovf  = 1'b1;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= full;
      end
      always_comb begin
        rword = '0;
        rword[F_TYPE +: TT_W]  = stat.ttype;
        rword[F_AOVF]          = stat.aovf;
        rword[F_OVF]           = stat.ovf;
        rword[F_MODE]          = stat.mode;
        rword[F_SAT +: SAT_W]  = stat.sat;
      end
    end else begin : g_plain
      mx_stat_t slim;
      always_comb begin
        slim       = '0;
        slim.ovf   = nxt.ovf;
        slim.sat   = nxt.sat;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= slim;
      end
      always_comb begin
        rword = '0;
        rword[F_OVF]          = stat.ovf;
        rword[F_SAT +: SAT_W] = stat.sat;
      end
    end
  endgenerate
endmodule

// File: rtl/media_exc_tracker.sv
module media_exc_tracker
  import mx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_variant,
  input  logic              rpt_valid,
  input  logic [TT_W-1:0]   rpt_type,
  input  logic [SAT_W-1:0]  rpt_sat,
  input  logic              rpt_slot,
  input  logic              trap_strobe,
  input  logic              sw_wr_en,
  input  logic              sw_sel,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata,
  output logic              irq_pulse
);
  localparam int NREG = 2;

  mx_stat_t          stat_a;
  mx_stat_t          stat_b;
  logic [DATA_W-1:0] word_a;
  logic [DATA_W-1:0] word_b;
  logic              type_load;
  logic              ovf_to_a;
  logic              ovf_to_b;
  logic              aovf_set;
  logic              irq_now;
  logic [NREG-1:0]   wr_hit;

  assign wr_hit[0] = sw_wr_en && !sw_sel;
  assign wr_hit[1] = sw_wr_en &&  sw_sel;

  mx_exc_decode u_dec (
    .alt_variant (alt_variant),
    .rpt_valid   (rpt_valid),
    .rpt_type    (rpt_type),
    .rpt_slot    (rpt_slot),
    .trap_strobe (trap_strobe),
    .cur_a       (stat_a),
    .type_load   (type_load),
    .ovf_to_a    (ovf_to_a),
    .ovf_to_b    (ovf_to_b),
    .aovf_set    (aovf_set),
    .irq_now     (irq_now)
  );

  mx_status_reg #(.HAS_CTRL(1'b1), .DATA_W(DATA_W)) u_reg_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_hit[0]),
    .wdata     (sw_wdata),
    .ovf_set   (ovf_to_a),
    .sat_or    (rpt_sat),
    .type_load (type_load),
    .type_val  (rpt_type),
    .aovf_set  (aovf_set),
    .stat      (stat_a),
    .rword     (word_a)
  );

  mx_status_reg #(.HAS_CTRL(1'b0), .DATA_W(DATA_W)) u_reg_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_hit[1]),
    .wdata     (sw_wdata),
    .ovf_set   (ovf_to_b),
    .sat_or    (rpt_sat),
    .type_load (1'b0),
    .type_val  (TT_NONE),
    .aovf_set  (1'b0),
    .stat      (stat_b),
    .rword     (word_b)
  );

  assign sw_rdata = sw_sel ? word_b : word_a;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= irq_now;
  end
endmodule

// File: rtl/mx_checker.sv
module mx_checker
  import mx_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            alt_variant,
  input logic            rpt_valid,
  input logic [TT_W-1:0] rpt_type,
  input logic            rpt_slot,
  input logic            trap_strobe,
  input logic            sw_wr_en,
  input logic            sw_sel,
  input logic            irq_pulse,
  input mx_stat_t        stat_a,
  input mx_stat_t        stat_b
);
  // R2
  sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_a.ttype != TT_NONE && !(sw_wr_en && !sw_sel)) |=> $stable(stat_a.ttype));

  // R7
  aovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_a.aovf && !(sw_wr_en && !sw_sel)) |=> stat_a.aovf);

  // R4
  slot_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_type == TT_OVF && !alt_variant && rpt_slot) |=> stat_b.ovf);

  // R5
  alt_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_type == TT_OVF && alt_variant) |=> stat_a.ovf);

  // R6
  imm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_type == TT_OVF && alt_variant && stat_a.mode) |=> irq_pulse);

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(trap_strobe) || ($past(rpt_valid) && $past(rpt_type) == TT_OVF)));

  // R9
  other_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_type != TT_OVF && !(sw_wr_en && sw_sel)) |=> $stable(stat_b));
endmodule

bind media_exc_tracker mx_checker u_mx_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .alt_variant (alt_variant),
  .rpt_valid   (rpt_valid),
  .rpt_type    (rpt_type),
  .rpt_slot    (rpt_slot),
  .trap_strobe (trap_strobe),
  .sw_wr_en    (sw_wr_en),
  .sw_sel      (sw_sel),
  .irq_pulse   (irq_pulse),
  .stat_a      (stat_a),
  .stat_b      (stat_b)
);

// File: tb/test_media_exc_tracker.sv
`timescale 1ns/1ps
module test_media_exc_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_variant = 1'b0;
  logic        rpt_valid = 1'b0;
  logic [2:0]  rpt_type = '0;
  logic [3:0]  rpt_sat = '0;
  logic        rpt_slot = 1'b0;
  logic        trap_strobe = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic        sw_sel = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        irq_pulse;

  always #4 clk = ~clk;

  media_exc_tracker i_media_exc_tracker (.*);

  int n_checks = 0;
  int n_fails  = 0;
  string phase_req = "R1";
  bit running = 1'b0;

  // reference state
  int a_type, a_aovf, a_ovf, a_mode, a_sat, b_ovf, b_sat, m_irq;

  function automatic logic [31:0] pack_a();
    logic [31:0] w = '0;
    w[2:0] = a_type[2:0]; w[3] = a_aovf[0]; w[4] = a_ovf[0];
    w[5] = a_mode[0]; w[11:8] = a_sat[3:0];
    return w;
  endfunction

  function automatic logic [31:0] pack_b();
    logic [31:0] w = '0;
    w[4] = b_ovf[0]; w[11:8] = b_sat[3:0];
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      a_type = 0; a_aovf = 0; a_ovf = 0; a_mode = 0; a_sat = 0;
      b_ovf = 0; b_sat = 0; m_irq = 0;
    end else begin
      int na_type, na_aovf, na_ovf, na_mode, na_sat, nb_ovf, nb_sat, hit;
      hit = (trap_strobe && (a_aovf != 0 || (a_type != 0 && !alt_variant))) ? 1 : 0;
      na_type = a_type; na_aovf = a_aovf; na_ovf = a_ovf; na_mode = a_mode;
      na_sat = a_sat; nb_ovf = b_ovf; nb_sat = b_sat;
      if (sw_wr_en && !sw_sel) begin
        na_type = sw_wdata[2:0]; na_aovf = sw_wdata[3]; na_ovf = sw_wdata[4];
        na_mode = sw_wdata[5]; na_sat = sw_wdata[11:8];
      end
      if (sw_wr_en && sw_sel) begin
        nb_ovf = sw_wdata[4]; nb_sat = sw_wdata[11:8];
      end
      if (rpt_valid) begin
        if (a_type == 0 && rpt_type != 0) na_type = rpt_type;
        if (rpt_type == 1) begin
          if (!alt_variant && rpt_slot) begin
            nb_ovf = 1; nb_sat = nb_sat | rpt_sat;
          end else begin
            na_ovf = 1; na_sat = na_sat | rpt_sat;
          end
          if (alt_variant && a_mode != 0) hit = 1;
          else na_aovf = 1;
        end
      end
      a_type = na_type; a_aovf = na_aovf; a_ovf = na_ovf; a_mode = na_mode;
      a_sat = na_sat; b_ovf = nb_ovf; b_sat = nb_sat; m_irq = hit;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (running) begin
      logic [31:0] exp_w, diff;
      string ftag;
      exp_w = sw_sel ? pack_b() : pack_a();
      diff  = exp_w ^ sw_rdata;
      n_checks++;
      if (diff != 0) begin
        if (diff[2:0] != 0)       ftag = "R2";
        else if (diff[3])         ftag = "R7";
        else if (diff[11:8] != 0 || diff[4]) ftag = "R3";
        else                      ftag = "R10";
        n_fails++;
        $display("FAIL %s/%s sel=%0d rdata actual=%h expected=%h",
                 phase_req, ftag, sw_sel, sw_rdata, exp_w);
      end
      n_checks++;
      if (irq_pulse !== m_irq[0]) begin
        n_fails++;
        $display("FAIL %s/R11 irq_pulse actual=%0b expected=%0b",
                 phase_req, irq_pulse, m_irq[0]);
      end
    end
  end

  task automatic drive(input logic v, input logic [2:0] t, input logic [3:0] s,
                       input logic sl, input logic tr, input logic we,
                       input logic sel, input logic [31:0] wd);
    @(negedge clk); #1;
    rpt_valid = v; rpt_type = t; rpt_sat = s; rpt_slot = sl;
    trap_strobe = tr; sw_wr_en = we; sw_sel = sel; sw_wdata = wd;
  endtask

  task automatic idle(input logic sel);
    drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, sel, 32'd0);
  endtask

  task automatic clear_all();
    drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0);
    drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0);
    idle(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    // R1: reset state of both registers and the interrupt line
    #2;
    n_checks++;
    if (sw_rdata !== 32'd0 || irq_pulse !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 reset rdata=%h irq=%0b expected 0/0", sw_rdata, irq_pulse);
    end
    sw_sel = 1'b1; #1;
    n_checks++;
    if (sw_rdata !== 32'd0) begin
      n_fails++;
      $display("FAIL R1 reset secondary rdata=%h expected 0", sw_rdata);
    end
    sw_sel = 1'b0;
    running = 1'b1;

    // R3 and R4: default policy, slot 0 then slot 1
    phase_req = "R4";
    drive(1'b1, 3'd1, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
    drive(1'b1, 3'd1, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b1, 32'd0);
    idle(1'b1); idle(1'b0);
    // R8: trap collects the accumulated overflow
    phase_req = "R8";
    drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    idle(1'b0); idle(1'b0);
    phase_req = "R10";
    clear_all();
    // R9: other cause touches only the cause field
    phase_req = "R9";
    drive(1'b1, 3'd3, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0);
    idle(1'b1); idle(1'b0);
    phase_req = "R8";
    drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    idle(1'b0);
    alt_variant = 1'b1;
    drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    idle(1'b0);
    // R2: a later cause does not replace the first
    phase_req = "R2";
    drive(1'b1, 3'd5, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
    idle(1'b0);
    phase_req = "R10";
    clear_all();
    // R5: alternate policy sends slot 1 overflow to primary
    phase_req = "R5";
    drive(1'b1, 3'd1, 4'b0101, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0);
    idle(1'b1); idle(1'b0);
    // R6: enable bit set, immediate interrupt and no accumulation
    phase_req = "R6";
    clear_all();
    drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h20);
    drive(1'b1, 3'd1, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
    idle(1'b0); idle(1'b0);
    alt_variant = 1'b0;
    // R10: write and overflow collide on the primary register
    phase_req = "R10";
    clear_all();
    drive(1'b1, 3'd1, 4'b0101, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0A00);
    idle(1'b0);
    drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    idle(1'b1);
    // R12: trap in the same cycle as the first overflow sees old state
    phase_req = "R12";
    clear_all();
    drive(1'b1, 3'd1, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    idle(1'b0); idle(1'b0);
    // R7: accumulation from slot 1 in default policy
    phase_req = "R7";
    clear_all();
    drive(1'b1, 3'd1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0);
    idle(1'b0);

    // mixed random traffic
    phase_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      logic v, sl, tr, we, sel;
      logic [2:0] t;
      if (($urandom % 50) == 0) alt_variant = ~alt_variant;
      v  = ($urandom % 3) == 0;
      t  = (($urandom % 2) == 0) ? 3'd1 : 3'($urandom);
      sl = 1'($urandom);
      tr = ($urandom % 6) == 0;
      we = ($urandom % 10) == 0;
      sel = 1'($urandom);
      drive(v, t, 4'($urandom), sl, tr, we, sel, $urandom);
    end
    idle(1'b0); idle(1'b0);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule